// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block turns a free-running reference clock into a periodic one-cycle enable tick, whose spacing is set by a small divisor code held in a register. A gate bit decides whether ticks reach the output at all. Downstream logic uses the tick as a clock enable, so the design never makes a derived clock of its own.

Software programs the block through a simple register port with three locations: control (gate bit), divisor code, and status. Two layouts exist, chosen by a parameter. The narrow layout uses a five-bit code. The wide layout uses a six-bit code, in which the top bit switches in a fixed divide-by-64 prescale on the low five bits. In both layouts a code of zero means the largest plain divisor. A divisor write starts a short busy window, reported in the status word. Writes made during that window are dropped. A new divisor is taken up only when the running count wraps, so no period is ever cut short.

Top module: `clkdiv_gated`

## Requirements
- R1: After reset, tick_o is 0 and all three registers read back 0 (gate off, divisor code 0, not busy).
- R2: A divisor code of 0 gives a tick spacing of 2^CODE_W cycles: 32 in the narrow layout and 64 in the wide one. Code 0x20 in the wide layout (prescale set, low bits zero) also gives 64.
- R3: A nonzero code with the prescale bit clear gives a tick spacing equal to the code, down to 1, which is a tick every cycle.
- R4: In the wide layout (CODE_W = 6), a code with bit 5 set and bits 4:0 equal to L, where L is nonzero, gives a spacing of 64*L cycles.
- R5: Ticks appear only while the gate bit (bit 0 at address 0) is 1. Reading address 0 returns the gate bit in bit 0.
- R6: A write to the divisor address (address 1) whose data has any bit set at or above bit CODE_W is rejected. The stored code is unchanged and no busy window starts.
- R7: An accepted divisor write makes the status word (address 2) read 0x18, with busy in bits 3 and 4, for BUSY_CYCLES cycles. After that it reads 0.
- R8: A divisor write made while busy is set is ignored.
- R9: A new divisor takes effect only at the next wrap of the count. The interval that is running when the write arrives completes at the old length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 divisor, 2 status |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address; data returns one cycle later |
| rd_data | output | 8 | Registered read data |
| tick_o | output | 1 | Registered one-cycle tick at the divided rate |

## Verification
The hardest case to reach from the ports is a divisor write that lands just after a wrap, while a long interval has only just begun. That is the only moment that shows whether the old period runs to completion. The bench waits for a tick at the output and issues the write in that same cycle. It then counts the cycles to the next tick and expects the old spacing, followed by the new one. The wide-layout prescale codes need intervals of close to two thousand cycles, so the bench measures only the second gap after each change.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_DIV  = 2'd1,
    SEL_STAT = 2'd2
  } reg_sel_e;

  localparam int STAT_BUSY_LO = 3;
  localparam int STAT_BUSY_HI = 4;
  localparam int PRESCALE_SH  = 6;
endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode #(
  parameter int CODE_W = 5,
  parameter bit WIDE   = 1'b0,
  parameter int CNT_W  = 6
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  div_o
);
  import clkdiv_pkg::*;
  localparam logic [CNT_W-1:0] FULL_DIV = CNT_W'(2 ** CODE_W);

  generate
    if (WIDE) begin : g_wide
      logic [CODE_W-2:0] low;
      assign low = code_i[CODE_W-2:0];
      always_comb begin
        if (code_i[CODE_W-1]) begin
          if (low == '0) div_o = FULL_DIV;
          else           div_o = CNT_W'(low) << PRESCALE_SH;
        end else if (code_i == '0) begin
          div_o = FULL_DIV;
        end else begin
          div_o = CNT_W'(code_i);
        end
      end
    end else begin : g_narrow
      always_comb begin
        if (code_i == '0) div_o = FULL_DIV;
        else              div_o = CNT_W'(code_i);
      end
    end
  endgenerate
endmodule

// File: rtl/clkdiv_regs.sv
module clkdiv_regs #(
  parameter int CODE_W      = 5,
  parameter int DATA_W      = 8,
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              gate_en,
  output logic [CODE_W-1:0] div_code
);
  import clkdiv_pkg::*;
  localparam int BW = $clog2(BUSY_CYCLES + 1);

  logic [BW-1:0] busy_cnt;
  logic          busy;
  logic          div_sel;
  logic          too_big;
  logic          div_take;

  assign busy     = (busy_cnt != '0);
  assign div_sel  = wr_en && (wr_addr == SEL_DIV);
  assign too_big  = |wr_data[DATA_W-1:CODE_W];
  assign div_take = div_sel && !too_big && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_en  <= 1'b0;
      div_code <= '0;
      busy_cnt <= '0;
    end else begin
      if (wr_en && (wr_addr == SEL_CTRL)) gate_en <= wr_data[0];
      if (div_take) begin
        div_code <= wr_data[CODE_W-1:0];
        busy_cnt <= BW'(BUSY_CYCLES);
      end else if (busy) begin
        busy_cnt <= busy_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      case (rd_addr)
        SEL_CTRL: rd_data[0] <= gate_en;
        SEL_DIV:  rd_data[CODE_W-1:0] <= div_code;
        SEL_STAT: begin
          rd_data[STAT_BUSY_LO] <= busy;
          rd_data[STAT_BUSY_HI] <= busy;
        end
        default: rd_data <= '0;
      endcase
    end
  end

  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (div_sel && too_big) |=> $stable(div_code)); // R6
  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (div_sel && busy) |=> $stable(div_code)); // R8
  AST_BUSY_STARTS: assert property (@(posedge clk) disable iff (rst)
    div_take |=> (busy_cnt != '0)); // R7
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int CNT_W   = 6,
  parameter int RST_DIV = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate_en,
  input  logic [CNT_W-1:0] div_next,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] div_act;
  logic             wrap;

  assign wrap = (cnt == div_act - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      div_act <= CNT_W'(RST_DIV);
      tick_o  <= 1'b0;
    end else begin
      tick_o <= gate_en && wrap;
      if (wrap) begin
        cnt     <= '0;
        div_act <= div_next;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_SWITCH_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    !$stable(div_act) |-> $past(wrap)); // R9
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt < div_act); // R3
  AST_TICK_GATED: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> $past(gate_en)); // R5
endmodule

// File: rtl/clkdiv_gated.sv
module clkdiv_gated #(
  parameter bit WIDE        = 1'b0,
  parameter int DATA_W      = 8,
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              tick_o
);
  localparam int CODE_W  = WIDE ? 6 : 5;
  localparam int MAX_DIV = WIDE ? ((2 ** (CODE_W - 1)) - 1) * 64 : 2 ** CODE_W;
  localparam int CNT_W   = $clog2(MAX_DIV + 1);
  localparam int RST_DIV = 2 ** CODE_W;

  logic              gate_en;
  logic [CODE_W-1:0] div_code;
  logic [CNT_W-1:0]  div_next;

  clkdiv_regs #(.CODE_W(CODE_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .gate_en(gate_en), .div_code(div_code)
  );

  clkdiv_decode #(.CODE_W(CODE_W), .WIDE(WIDE), .CNT_W(CNT_W)) u_dec (
    .code_i(div_code), .div_o(div_next)
  );

  clkdiv_counter #(.CNT_W(CNT_W), .RST_DIV(RST_DIV)) u_cnt (
    .clk(clk), .rst(rst), .gate_en(gate_en), .div_next(div_next), .tick_o(tick_o)
  );

  AST_ZERO_IS_FULL: assert property (@(posedge clk) disable iff (rst)
    (div_code == '0) |-> (div_next == CNT_W'(RST_DIV))); // R2
endmodule

// File: tb/tb_clkdiv_gated.sv
module tb_clkdiv_gated;
  localparam int BUSY = 4;
  localparam int VEC[6][2] = '{'{0, 32}, '{1, 1}, '{2, 2}, '{5, 5}, '{31, 31}, '{17, 17}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_n = 1'b0, wr_w = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_n, rd_w;
  logic tick_n, tick_w;
  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  clkdiv_gated #(.WIDE(1'b0), .BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_n), .tick_o(tick_n));
  clkdiv_gated #(.WIDE(1'b1), .BUSY_CYCLES(BUSY)) dut_w (
    .clk(clk), .rst(rst), .wr_en(wr_w), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_w), .tick_o(tick_w));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic tk(input bit s);
    return s ? tick_w : tick_n;
  endfunction

  task automatic do_wr(input bit s, input logic [1:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d;
    if (s) wr_w = 1'b1; else wr_n = 1'b1;
    @(negedge clk);
    wr_n = 1'b0; wr_w = 1'b0;
  endtask

  task automatic do_rd(input bit s, input logic [1:0] a, output int v);
    rd_addr = a;
    @(negedge clk);
    v = s ? int'(rd_w) : int'(rd_n);
  endtask

  task automatic idle();
    repeat (BUSY + 2) @(negedge clk);
  endtask

  task automatic gap(input bit s, output int g);
    int w = 0;
    while (!tk(s) && w < 5000) begin @(negedge clk); w++; end
    g = 0;
    do begin @(negedge clk); g++; end while (!tk(s) && g < 5000);
  endtask

  task automatic set_and_measure(input bit s, input int code, output int g);
    int d;
    idle();
    do_wr(s, 2'd1, 8'(code));
    gap(s, d);
    gap(s, g);
  endtask

  initial begin
    int v, g, n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 tick", int'(tick_n), 0);
    do_rd(0, 2'd0, v); chk("R1 ctrl", v, 0);
    do_rd(0, 2'd1, v); chk("R1 div", v, 0);
    do_rd(0, 2'd2, v); chk("R1 status", v, 0);

    // R5 gate readback and enable
    do_wr(0, 2'd0, 8'h01);
    do_rd(0, 2'd0, v); chk("R5 gate readback", v, 1);

    // R2/R3 vector table walk on the narrow layout
    foreach (VEC[i]) begin
      set_and_measure(0, VEC[i][0], g);
      chk(VEC[i][0] == 0 ? "R2 zero code spacing" : "R3 code spacing", g, VEC[i][1]);
    end

    // R7 busy window
    idle();
    do_wr(0, 2'd1, 8'd6);
    do_rd(0, 2'd2, v); chk("R7 busy set", v, 8'h18);
    repeat (BUSY + 2) @(negedge clk);
    do_rd(0, 2'd2, v); chk("R7 busy clear", v, 0);

    // R8 write while busy dropped
    do_wr(0, 2'd1, 8'd3);
    do_wr(0, 2'd1, 8'd7);
    do_rd(0, 2'd1, v); chk("R8 busy write dropped", v, 3);

    // R6 out-of-range code rejected
    idle();
    do_wr(0, 2'd1, 8'h25);
    do_rd(0, 2'd2, v); chk("R6 no busy", v, 0);
    do_rd(0, 2'd1, v); chk("R6 code kept", v, 3);

    // R9 switch only at wrap
    set_and_measure(0, 31, g);
    chk("R9 setup spacing", g, 31);
    idle();
    while (!tick_n) @(negedge clk);
    wr_addr = 2'd1; wr_data = 8'd2; wr_n = 1'b1;
    n = 0;
    do begin @(negedge clk); wr_n = 1'b0; n++; end while (!tick_n && n < 100);
    chk("R9 old interval completes", n, 31);
    gap(0, g); chk("R9 new spacing", g, 2);

    // R5 gate off suppresses ticks
    do_wr(0, 2'd0, 8'h00);
    @(negedge clk);
    n = 0;
    repeat (80) begin @(negedge clk); if (tick_n) n++; end
    chk("R5 no ticks gated", n, 0);
    do_rd(0, 2'd0, v); chk("R5 gate off readback", v, 0);

    // Wide layout
    do_wr(1, 2'd0, 8'h01);
    gap(1, g); gap(1, g); chk("R2 wide zero code", g, 64);
    set_and_measure(1, 8'h20, g); chk("R2 wide prescale zero", g, 64);
    set_and_measure(1, 8'h23, g); chk("R4 prescale x3", g, 192);
    set_and_measure(1, 8'h01, g); chk("R3 wide code 1", g, 1);
    set_and_measure(1, 8'h3F, g); chk("R4 prescale x31", g, 1984);
    idle();
    do_wr(1, 2'd1, 8'h40);
    do_rd(1, 2'd1, v); chk("R6 wide reject", v, 8'h3F);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule